// File: doc/BRIEF.md
# Low-Power Stop Entry Sequencer

This block carries a processor core through its low-power stop instruction. It watches the instruction word stream for a fixed two-word opcode and then takes a third word as a 16-bit immediate. If the core is in supervisor mode, it runs one write broadcast cycle on the system bus. When that cycle terminates, it samples bus grant to decide how the bus is left for the rest of the stop. It then loads the immediate into the status register, reports the stopped state and turns off the core clock enable.

While stopped, only reset and the interrupt priority level are looked at. Either one ends the stop and hands control to exception processing. If the instruction arrives in user mode, nothing is broadcast and a privilege-violation exception request is raised instead. Exception processing holds until the downstream handler acknowledges it.

Top module: `lps_seq`

## Requirements
- R1: A stop starts only after the word 0xF800 and then the word 0x01C0 are accepted (instr_valid high). The next accepted word is the immediate. An 0xF800 in place of the second word restarts matching, and any other word drops the match.
- R2: If status bit 13 (supervisor) of sr_in is 0 when the immediate is accepted, no broadcast occurs. The block goes straight to exception processing with exc_kind 2'b01 (privilege).
- R3: Once the immediate is accepted in supervisor mode, bus_req is high and pst is 3'b101 from the next cycle on. This lasts until a cycle in which bus_ack or bus_err is high, and there is exactly one such broadcast per instruction.
- R4: bus_grant is sampled in the terminating cycle. From the next cycle until the stop ends, bus_park is high if grant was 1, and bus_float is high if grant was 0. The two are never high together.
- R5: In the cycle after termination, sr_load pulses high for one cycle and sr_value equals the immediate.
- R6: In the cycle after the status-register load, pst becomes 3'b110 and core_clk_en becomes 0. Both hold for as long as the block is stopped.
- R7: While stopped, instr_valid, instr_word, sr_in, bus_ack, bus_err, bus_grant and exc_ack have no effect on any output.
- R8: While stopped, an ipl value greater than immediate bits 10:8, or an ipl of 7, moves the block to exception processing in the next cycle. exc_kind is then 2'b10 and exc_level equals that ipl. Lower nonzero levels, and ipl 0, do not wake it.
- R9: A high reset_req in any state moves the block to exception processing in the next cycle, with exc_kind 2'b11.
- R10: In exception processing, pst is 3'b111 and exc_req is high until exc_ack is seen. The next cycle returns pst 3'b000 with core_clk_en 1.
- R11: On every stop the pst codes run in this order: 000, 101, 110, 111, 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 16 | Instruction word |
| sr_in | input | 16 | Current status register |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_err | input | 1 | Transfer error acknowledge |
| bus_grant | input | 1 | Bus grant |
| ipl | input | 3 | Interrupt priority level, 0 = none |
| reset_req | input | 1 | Reset request (wake source) |
| exc_ack | input | 1 | Exception handler has taken the request |
| bus_req | output | 1 | Write broadcast cycle active |
| bus_park | output | 1 | Drive bus outputs high |
| bus_float | output | 1 | Tri-state bus outputs |
| sr_load | output | 1 | Status register load strobe |
| sr_value | output | 16 | Value for the status register |
| pst | output | 3 | Processor status code |
| core_clk_en | output | 1 | Core clock enable |
| exc_req | output | 1 | Exception processing request |
| exc_kind | output | 2 | 01 privilege, 10 interrupt, 11 reset |
| exc_level | output | 3 | Interrupt level that woke the block |

## Verification
Entries are run with bus grant held and with grant dropped, and are ended by an acknowledge after several wait cycles and by an error acknowledge. This separates the two bus-parking outcomes and shows that the sampling happens only at termination. Wake tests sweep ipl values below, equal to and above the loaded mask, plus level 7 under a mask of 7, which separates a strict compare from an off-by-one one. Broken opcode sequences, user-mode entry, junk inputs while stopped, and a reset request in the middle of a broadcast check the paths away from the normal flow.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MATCH = 3'd1,
        ST_IMM   = 3'd2,
        ST_BCAST = 3'd3,
        ST_LOAD  = 3'd4,
        ST_STOP  = 3'd5,
        ST_EXC   = 3'd6
    } lps_state_e;

    localparam logic [2:0] PST_RUN   = 3'b000;
    localparam logic [2:0] PST_BCAST = 3'b101;
    localparam logic [2:0] PST_STOP  = 3'b110;
    localparam logic [2:0] PST_EXC   = 3'b111;

    localparam logic [1:0] EXC_NONE  = 2'b00;
    localparam logic [1:0] EXC_PRIV  = 2'b01;
    localparam logic [1:0] EXC_INT   = 2'b10;
    localparam logic [1:0] EXC_RESET = 2'b11;

endpackage

// File: rtl/lps_decode.sv
module lps_decode #(
    parameter int          DATA_W    = 16,
    parameter logic [15:0] OP_FIRST  = 16'hF800,
    parameter logic [15:0] OP_SECOND = 16'h01C0
) (
    input  logic [DATA_W-1:0] word,
    output logic              is_first,
    output logic              is_second
);
    localparam logic [DATA_W-1:0] FIRST_W  = DATA_W'(OP_FIRST);
    localparam logic [DATA_W-1:0] SECOND_W = DATA_W'(OP_SECOND);

    always_comb begin
        is_first  = (word == FIRST_W);
        is_second = (word == SECOND_W);
    end
endmodule

// File: rtl/lps_wake.sv
module lps_wake #(
    parameter int IPL_W   = 3,
    parameter bit TOP_NMI = 1'b1
) (
    input  logic [IPL_W-1:0] ipl,
    input  logic [IPL_W-1:0] mask,
    output logic             wake
);
    localparam logic [IPL_W-1:0] TOP_LEVEL = '1;

    logic above;
    assign above = (ipl > mask);

    generate
        if (TOP_NMI) begin : g_nmi
            assign wake = above || (ipl == TOP_LEVEL);
        end else begin : g_plain
            assign wake = above;
        end
    endgenerate
endmodule

// File: rtl/lps_outmap.sv
module lps_outmap
    import lps_pkg::*;
(
    input  lps_state_e state,
    input  logic       park,
    output logic [2:0] pst,
    output logic       bus_req,
    output logic       bus_park,
    output logic       bus_float,
    output logic       sr_load,
    output logic       core_clk_en,
    output logic       exc_req
);
    logic held;

    always_comb begin
        pst         = PST_RUN;
        bus_req     = 1'b0;
        sr_load     = 1'b0;
        core_clk_en = 1'b1;
        exc_req     = 1'b0;
        held        = 1'b0;
        unique case (state)
            ST_BCAST: begin
                pst     = PST_BCAST;
                bus_req = 1'b1;
            end
            ST_LOAD: begin
                pst     = PST_BCAST;
                sr_load = 1'b1;
                held    = 1'b1;
            end
            ST_STOP: begin
                pst         = PST_STOP;
                core_clk_en = 1'b0;
                held        = 1'b1;
            end
            ST_EXC: begin
                pst     = PST_EXC;
                exc_req = 1'b1;
            end
            default: ;
        endcase
        bus_park  = held && park;
        bus_float = held && !park;
    end
endmodule

// File: rtl/lps_seq.sv
module lps_seq
    import lps_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          IPL_W     = 3,
    parameter int          SUP_BIT   = 13,
    parameter int          MASK_LSB  = 8,
    parameter logic [15:0] OP_FIRST  = 16'hF800,
    parameter logic [15:0] OP_SECOND = 16'h01C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [DATA_W-1:0] instr_word,
    input  logic [DATA_W-1:0] sr_in,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic              bus_grant,
    input  logic [IPL_W-1:0]  ipl,
    input  logic              reset_req,
    input  logic              exc_ack,
    output logic              bus_req,
    output logic              bus_park,
    output logic              bus_float,
    output logic              sr_load,
    output logic [DATA_W-1:0] sr_value,
    output logic [2:0]        pst,
    output logic              core_clk_en,
    output logic              exc_req,
    output logic [1:0]        exc_kind,
    output logic [IPL_W-1:0]  exc_level
);

    typedef struct packed {
        lps_state_e        state;
        logic [DATA_W-1:0] imm;
        logic              park;
        logic [1:0]        kind;
        logic [IPL_W-1:0]  level;
    } regs_t;

    regs_t r_q, r_d;

    logic             is_first, is_second, wake;
    logic [IPL_W-1:0] mask;

    assign mask = r_q.imm[MASK_LSB +: IPL_W];

    lps_decode #(
        .DATA_W   (DATA_W),
        .OP_FIRST (OP_FIRST),
        .OP_SECOND(OP_SECOND)
    ) u_decode (
        .word     (instr_word),
        .is_first (is_first),
        .is_second(is_second)
    );

    lps_wake #(
        .IPL_W  (IPL_W),
        .TOP_NMI(1'b1)
    ) u_wake (
        .ipl (ipl),
        .mask(mask),
        .wake(wake)
    );

    lps_outmap u_outmap (
        .state      (r_q.state),
        .park       (r_q.park),
        .pst        (pst),
        .bus_req    (bus_req),
        .bus_park   (bus_park),
        .bus_float  (bus_float),
        .sr_load    (sr_load),
        .core_clk_en(core_clk_en),
        .exc_req    (exc_req)
    );

    always_comb begin
        r_d = r_q;
        if (reset_req) begin
            r_d.state = ST_EXC;
            r_d.kind  = EXC_RESET;
            r_d.level = '0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (instr_valid && is_first) r_d.state = ST_MATCH;
                end
                ST_MATCH: begin
                    if (instr_valid) begin
                        if (is_second)     r_d.state = ST_IMM;
                        else if (is_first) r_d.state = ST_MATCH;
                        else               r_d.state = ST_IDLE;
                    end
                end
                ST_IMM: begin
                    if (instr_valid) begin
                        r_d.imm = instr_word;
                        if (sr_in[SUP_BIT]) begin
                            r_d.state = ST_BCAST;
                        end else begin
                            r_d.state = ST_EXC;
                            r_d.kind  = EXC_PRIV;
                            r_d.level = '0;
                        end
                    end
                end
                ST_BCAST: begin
                    if (bus_ack || bus_err) begin
                        r_d.park  = bus_grant;
                        r_d.state = ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    r_d.state = ST_STOP;
                end
                ST_STOP: begin
                    if (wake) begin
                        r_d.state = ST_EXC;
                        r_d.kind  = EXC_INT;
                        r_d.level = ipl;
                    end
                end
                ST_EXC: begin
                    if (exc_ack) begin
                        r_d.state = ST_IDLE;
                        r_d.kind  = EXC_NONE;
                        r_d.level = '0;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.imm   <= '0;
            r_q.park  <= 1'b0;
            r_q.kind  <= EXC_NONE;
            r_q.level <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sr_value  = r_q.imm;
    assign exc_kind  = r_q.kind;
    assign exc_level = r_q.level;

endmodule

// File: rtl/lps_seq_chk.sv
module lps_seq_chk #(
    parameter int IPL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_ack,
    input logic             bus_err,
    input logic [IPL_W-1:0] ipl,
    input logic             reset_req,
    input logic             bus_req,
    input logic             bus_park,
    input logic             bus_float,
    input logic             sr_load,
    input logic [2:0]       pst,
    input logic             core_clk_en,
    input logic             exc_req,
    input logic [1:0]       exc_kind
);
    localparam logic [IPL_W-1:0] TOP = '1;

    p_bcast_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> pst == 3'b101);

    p_park_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_park && bus_float));

    p_load_after_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load |-> ($past(bus_req) && ($past(bus_ack) || $past(bus_err))));

    p_stop_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pst == 3'b110) |-> !core_clk_en);

    p_stop_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((pst == 3'b110) && ($past(pst) != 3'b110)) |-> $past(sr_load));

    p_top_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pst == 3'b110) && !reset_req && (ipl == TOP)) |=> (pst == 3'b111));

    p_reset_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (exc_req && exc_kind == 2'b11));

    p_exc_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> pst == 3'b111);
endmodule

bind lps_seq lps_seq_chk #(.IPL_W(IPL_W)) u_lps_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .ipl        (ipl),
    .reset_req  (reset_req),
    .bus_req    (bus_req),
    .bus_park   (bus_park),
    .bus_float  (bus_float),
    .sr_load    (sr_load),
    .pst        (pst),
    .core_clk_en(core_clk_en),
    .exc_req    (exc_req),
    .exc_kind   (exc_kind)
);

// File: tb/test_lps_seq.sv
`timescale 1ns/1ps
module test_lps_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic [15:0] sr_in = 16'h2000;
    logic        bus_ack = 1'b0, bus_err = 1'b0, bus_grant = 1'b0;
    logic [2:0]  ipl = '0;
    logic        reset_req = 1'b0, exc_ack = 1'b0;
    logic        bus_req, bus_park, bus_float, sr_load, core_clk_en, exc_req;
    logic [15:0] sr_value;
    logic [2:0]  pst, exc_level;
    logic [1:0]  exc_kind;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lps_seq i_lps_seq (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .sr_in(sr_in), .bus_ack(bus_ack), .bus_err(bus_err), .bus_grant(bus_grant),
        .ipl(ipl), .reset_req(reset_req), .exc_ack(exc_ack), .bus_req(bus_req),
        .bus_park(bus_park), .bus_float(bus_float), .sr_load(sr_load),
        .sr_value(sr_value), .pst(pst), .core_clk_en(core_clk_en), .exc_req(exc_req),
        .exc_kind(exc_kind), .exc_level(exc_level)
    );

    // Behavioural reference: phase 0 run, 1 saw first word, 2 want operand,
    // 3 broadcasting, 4 loading SR, 5 stopped, 6 exception.
    int          ph = 0;
    logic [15:0] m_imm = '0;
    bit          m_grant = 0;
    int          m_kind = 0, m_lvl = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0; m_imm = '0; m_grant = 0; m_kind = 0; m_lvl = 0;
        end else if (reset_req) begin
            ph = 6; m_kind = 3; m_lvl = 0;
        end else if (ph == 0) begin
            if (instr_valid && instr_word == 16'hF800) ph = 1;
        end else if (ph == 1) begin
            if (instr_valid) ph = (instr_word == 16'h01C0) ? 2 : ((instr_word == 16'hF800) ? 1 : 0);
        end else if (ph == 2) begin
            if (instr_valid) begin
                m_imm = instr_word;
                if (sr_in[13]) ph = 3;
                else begin ph = 6; m_kind = 1; m_lvl = 0; end
            end
        end else if (ph == 3) begin
            if (bus_ack || bus_err) begin m_grant = bus_grant; ph = 4; end
        end else if (ph == 4) begin
            ph = 5;
        end else if (ph == 5) begin
            if (ipl == 7 || int'(ipl) > int'(m_imm[10:8])) begin
                ph = 6; m_kind = 2; m_lvl = int'(ipl);
            end
        end else if (ph == 6) begin
            if (exc_ack) begin ph = 0; m_kind = 0; m_lvl = 0; end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    int pst_trace[$];
    int last_pst = 0;

    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            int e_pst;
            e_pst = (ph == 3 || ph == 4) ? 5 : (ph == 5) ? 6 : (ph == 6) ? 7 : 0;
            chk(int'(pst) == e_pst, "R11 pst", int'(pst), e_pst);
            chk(bus_req == (ph == 3), "R3 bus_req", int'(bus_req), int'(ph == 3));
            chk(bus_park == ((ph == 4 || ph == 5) && m_grant), "R4 bus_park",
                int'(bus_park), int'((ph == 4 || ph == 5) && m_grant));
            chk(bus_float == ((ph == 4 || ph == 5) && !m_grant), "R4 bus_float",
                int'(bus_float), int'((ph == 4 || ph == 5) && !m_grant));
            chk(sr_load == (ph == 4), "R5 sr_load", int'(sr_load), int'(ph == 4));
            chk(sr_value == m_imm, "R5 sr_value", int'(sr_value), int'(m_imm));
            chk(core_clk_en == (ph != 5), "R6 core_clk_en", int'(core_clk_en), int'(ph != 5));
            chk(exc_req == (ph == 6), "R10 exc_req", int'(exc_req), int'(ph == 6));
            if (ph == 6) begin
                chk(int'(exc_kind) == m_kind, "R9 exc_kind", int'(exc_kind), m_kind);
                chk(int'(exc_level) == m_lvl, "R8 exc_level", int'(exc_level), m_lvl);
            end
            if (int'(pst) != last_pst) pst_trace.push_back(int'(pst));
            last_pst = int'(pst);
        end
    end

    task automatic put(input logic [15:0] w);
        @(negedge clk); instr_valid = 1'b1; instr_word = w;
        @(negedge clk); instr_valid = 1'b0; instr_word = '0;
    endtask

    task automatic trace_is(input int a, input int b, input int c, input int d);
        int exp[$];
        exp = {};
        if (a >= 0) exp.push_back(a);
        if (b >= 0) exp.push_back(b);
        if (c >= 0) exp.push_back(c);
        if (d >= 0) exp.push_back(d);
        chk(pst_trace.size() == exp.size(), "R11 trace length", pst_trace.size(), exp.size());
        if (pst_trace.size() == exp.size())
            foreach (exp[i]) chk(pst_trace[i] == exp[i], "R11 trace order", pst_trace[i], exp[i]);
        pst_trace = {};
    endtask

    // Enter the stop: operand, grant value at termination, wait cycles, error ending.
    task automatic enter(input logic [15:0] imm, input bit g, input int waits, input bit use_err);
        put(16'hF800); put(16'h01C0); put(imm);
        chk(bus_req && pst == 3'b101, "R3 broadcast open", int'(pst), 5);
        bus_grant = ~g;
        for (int i = 0; i < waits; i++) @(negedge clk);
        bus_grant = g;
        if (use_err) bus_err = 1'b1; else bus_ack = 1'b1;
        @(negedge clk); bus_ack = 1'b0; bus_err = 1'b0; bus_grant = ~g;
        chk(sr_load && sr_value == imm, "R5 load strobe", int'(sr_value), int'(imm));
        @(negedge clk);
        chk(pst == 3'b110 && !core_clk_en, "R6 stopped", int'(pst), 6);
        chk(bus_park == g && bus_float == !g, "R4 bus mode", int'(bus_park), int'(g));
    endtask

    task automatic leave();
        @(negedge clk);
        chk(exc_req && pst == 3'b111, "R10 exception held", int'(pst), 7);
        exc_ack = 1'b1;
        @(negedge clk); exc_ack = 1'b0;
        chk(pst == 3'b000 && core_clk_en, "R10 back to run", int'(pst), 0);
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pst == 3'b000 && !bus_req && core_clk_en && !exc_req, "R10 reset state", int'(pst), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: broken sequences start nothing
        put(16'hF800); put(16'h1234); put(16'h01C0); put(16'h2700);
        repeat (2) @(negedge clk);
        chk(pst == 3'b000 && !bus_req, "R1 broken opcode ignored", int'(pst), 0);
        pst_trace = {};

        // R1/R8: repeated first word, grant held, masked levels then wake at 4
        put(16'hF800);
        enter(16'h2300, 1'b1, 3, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            instr_valid = 1'b1; instr_word = 16'hF800; bus_ack = 1'b1; bus_grant = i[0];
            sr_in = 16'h0000; exc_ack = 1'b1; ipl = (i < 2) ? 3'd2 : 3'd3;
        end
        @(negedge clk);
        chk(pst == 3'b110 && !core_clk_en && bus_park && !bus_req && !sr_load,
            "R7 inputs ignored while stopped", int'(pst), 6);
        instr_valid = 1'b0; bus_ack = 1'b0; exc_ack = 1'b0; sr_in = 16'h2000;
        chk(pst == 3'b110, "R8 level at mask does not wake", int'(pst), 6);
        ipl = 3'd4;
        @(negedge clk); ipl = 3'd0;
        chk(exc_kind == 2'b10 && exc_level == 3'd4, "R8 level above mask wakes", int'(exc_level), 4);
        leave();
        trace_is(5, 6, 7, 0);

        // R4/R8: grant removed, error ending, mask 7: level 6 sleeps, level 7 wakes
        enter(16'h2700, 1'b0, 0, 1'b1);
        ipl = 3'd6;
        repeat (3) @(negedge clk);
        chk(pst == 3'b110 && bus_float, "R8 level 6 under mask 7 sleeps", int'(pst), 6);
        ipl = 3'd7;
        @(negedge clk); ipl = 3'd0;
        chk(exc_kind == 2'b10 && exc_level == 3'd7, "R8 level 7 always wakes", int'(exc_level), 7);
        leave();
        trace_is(5, 6, 7, 0);

        // R2: user mode
        sr_in = 16'h0000;
        put(16'hF800); put(16'h01C0); put(16'h2000);
        chk(!bus_req && exc_req && exc_kind == 2'b01, "R2 privilege request", int'(exc_kind), 1);
        sr_in = 16'h2000;
        leave();
        trace_is(7, 0, -1, -1);

        // R9: reset while stopped
        enter(16'h2700, 1'b1, 1, 1'b0);
        reset_req = 1'b1;
        @(negedge clk); reset_req = 1'b0;
        chk(exc_req && exc_kind == 2'b11, "R9 reset wakes stop", int'(exc_kind), 3);
        leave();
        trace_is(5, 6, 7, 0);

        // R9: reset in the middle of a broadcast
        put(16'hF800); put(16'h01C0); put(16'h2500);
        @(negedge clk);
        reset_req = 1'b1;
        @(negedge clk); reset_req = 1'b0;
        chk(!bus_req && exc_kind == 2'b11, "R9 reset during broadcast", int'(exc_kind), 3);
        leave();
        trace_is(5, 7, 0, -1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule